// File: doc/BRIEF.md
# Free-Hole Memory Allocator

This block keeps a small table of free memory regions ("holes"). Each entry holds a start address, a size and a valid flag. An allocation command asks for a number of units under one of four placement policies. The block picks a hole, hands back that hole's start address, and shrinks the hole in place, so the leftover stays free at the same table index. A free command gives a region back. The region is joined onto any hole that ends exactly where it begins or begins exactly where it ends. If there is no such neighbour, it goes into the lowest empty entry. A read command returns one entry so that the table can be inspected through the normal request path.

Requests are accepted when `req_valid` is high and `busy` is low. The search walks the table one entry per cycle. First fit and next fit stop at the first hole that is large enough. Best fit, worst fit and free examine every entry. A single commit cycle follows the search. It updates the table and presents a one-cycle response carrying a status, an address and a size.

Top module: `hole_alloc`

## Requirements
- R1: After reset `busy` and `resp_valid` are low and every entry is empty: a read of any index returns status 3 (empty) with address and size 0.
- R2: Alloc (cmd 0) with policy 0 (first fit) picks the lowest-index valid hole whose size is at least the request. It returns status 0 with that hole's start address. The hole keeps its index, its start advances by the request and its size shrinks by the request.
- R3: Policy 1 (next fit) behaves as first fit, except that the search starts at the index chosen by the last successful allocation (index 0 after reset) and wraps past the last entry to index 0.
- R4: Policy 2 (best fit) picks the smallest valid hole that is large enough. Ties go to the lowest index.
- R5: Policy 3 (worst fit) picks the largest valid hole, provided it is large enough. Ties go to the lowest index.
- R6: When no hole is large enough, the response has status 1 (no fit) and address 0. The table and the next-fit start index are left unchanged.
- R7: A successful alloc returns the leftover size in `resp_size`. A hole whose leftover reaches zero becomes empty.
- R8: Free (cmd 1) of a region with no adjacent hole stores it in the lowest empty entry. The response carries status 0 with that region's start and size.
- R9: On free, a hole ending at the freed start grows by the freed size. A hole starting at the freed end moves its start down to the freed start. When both exist, the lower entry takes the combined size and the upper entry becomes empty. The response carries the merged hole's start and size.
- R10: A free that needs a new entry while all entries are valid returns status 2 (overflow) and leaves the table unchanged.
- R11: `busy` is high from the cycle after acceptance until the response. `resp_valid` is a one-cycle pulse while `busy` is low. Counted in cycles with `busy` high: a first- or next-fit hit on the k-th entry examined (counting from 0) takes k+2, a full scan takes NH+1, and a read takes 1.
- R12: Read (cmd 2) returns the entry whose index is the low bits of `req_addr`. A valid entry gives status 0 with its start and size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; accepted when busy is low |
| req_cmd | input | 2 | 0 alloc, 1 free, 2 read |
| req_policy | input | 2 | 0 first, 1 next, 2 best, 3 worst fit |
| req_size | input | AW | Units to allocate or free |
| req_addr | input | AW | Freed region start, or entry index for read |
| busy | output | 1 | Command in progress |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_status | output | 2 | 0 ok, 1 no fit, 2 overflow, 3 empty |
| resp_addr | output | AW | Granted start, merged hole start, or entry start |
| resp_size | output | AW | Leftover, merged or entry size |

## Verification
The merge with both neighbours is the one case where two table updates fall in the same commit edge: the lower hole is rewritten with the summed size and the upper hole is cleared. The bench provokes it by freeing exactly the gap between two stored holes. It then judges the result from the response size and from read-backs of both entries, one expected to hold the merged span and the other expected to be empty. The same free path is also run against a full table, where a merge must still succeed while a non-adjacent free must report overflow.

// File: rtl/hole_pkg.sv
package hole_pkg;
  typedef enum logic [1:0] {CMD_ALLOC = 2'd0, CMD_FREE = 2'd1, CMD_READ = 2'd2, CMD_RSVD = 2'd3} cmd_e;
  typedef enum logic [1:0] {POL_FIRST = 2'd0, POL_NEXT = 2'd1, POL_BEST = 2'd2, POL_WORST = 2'd3} pol_e;
  typedef enum logic [1:0] {ST_OK = 2'd0, ST_NOFIT = 2'd1, ST_OVFL = 2'd2, ST_EMPTY = 2'd3} stat_e;
  typedef enum logic [1:0] {S_IDLE = 2'd0, S_SCAN = 2'd1, S_COMMIT = 2'd2} fsm_e;
endpackage

// File: rtl/hole_table.sv
module hole_table #(
  parameter int NH = 8,
  parameter int AW = 16,
  localparam int IW = $clog2(NH)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wa_en,
  input  logic [IW-1:0]          wa_idx,
  input  logic                   wa_valid,
  input  logic [AW-1:0]          wa_start,
  input  logic [AW-1:0]          wa_size,
  input  logic                   wb_en,
  input  logic [IW-1:0]          wb_idx,
  output logic [NH-1:0]          ent_valid,
  output logic [NH-1:0][AW-1:0]  ent_start,
  output logic [NH-1:0][AW-1:0]  ent_size
);
  // Port A rewrites a whole entry; port B only clears the valid flag.
  for (genvar i = 0; i < NH; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_valid[i] <= 1'b0;
        ent_start[i] <= '0;
        ent_size[i]  <= '0;
      end else if (wa_en && wa_idx == IW'(i)) begin
        ent_valid[i] <= wa_valid;
        ent_start[i] <= wa_start;
        ent_size[i]  <= wa_size;
      end else if (wb_en && wb_idx == IW'(i)) begin
        ent_valid[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/hole_scan.sv
module hole_scan
  import hole_pkg::*;
#(
  parameter int NH = 8,
  parameter int AW = 16,
  localparam int IW = $clog2(NH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          step,
  input  logic          is_alloc,
  input  pol_e          policy,
  input  logic [AW-1:0] want_size,
  input  logic [AW-1:0] want_addr,
  input  logic [IW-1:0] idx,
  input  logic          ent_v,
  input  logic [AW-1:0] ent_s,
  input  logic [AW-1:0] ent_z,
  output logic          fit_hit,
  output logic          sel_found,
  output logic [IW-1:0] sel_idx,
  output logic [AW-1:0] sel_size,
  output logic          left_found,
  output logic [IW-1:0] left_idx,
  output logic          right_found,
  output logic [IW-1:0] right_idx,
  output logic          slot_found,
  output logic [IW-1:0] slot_idx
);
  function automatic logic fits(logic v, logic [AW-1:0] have, logic [AW-1:0] want);
    return v && (have >= want);
  endfunction

  // Strict comparison keeps the earliest index on ties.
  function automatic logic prefer(pol_e pol, logic found, logic [AW-1:0] cand, logic [AW-1:0] best);
    if (!found) return 1'b1;
    case (pol)
      POL_BEST:  return cand < best;
      POL_WORST: return cand > best;
      default:   return 1'b0;
    endcase
  endfunction

  function automatic logic [AW-1:0] hole_end(logic [AW-1:0] start, logic [AW-1:0] len);
    return start + len;
  endfunction

  logic take, is_left, is_right, is_slot;

  assign fit_hit  = fits(ent_v, ent_z, want_size);
  assign take     = is_alloc && fit_hit && prefer(policy, sel_found, ent_z, sel_size);
  assign is_left  = !is_alloc && ent_v && (hole_end(ent_s, ent_z) == want_addr);
  assign is_right = !is_alloc && ent_v && (ent_s == hole_end(want_addr, want_size));
  assign is_slot  = !is_alloc && !ent_v;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      sel_found   <= 1'b0;
      sel_idx     <= '0;
      sel_size    <= '0;
      left_found  <= 1'b0;
      left_idx    <= '0;
      right_found <= 1'b0;
      right_idx   <= '0;
      slot_found  <= 1'b0;
      slot_idx    <= '0;
    end else if (step) begin
      if (take) begin
        sel_found <= 1'b1;
        sel_idx   <= idx;
        sel_size  <= ent_z;
      end
      if (is_left && !left_found) begin
        left_found <= 1'b1;
        left_idx   <= idx;
      end
      if (is_right && !right_found) begin
        right_found <= 1'b1;
        right_idx   <= idx;
      end
      if (is_slot && !slot_found) begin
        slot_found <= 1'b1;
        slot_idx   <= idx;
      end
    end
  end
endmodule

// File: rtl/hole_alloc.sv
module hole_alloc
  import hole_pkg::*;
#(
  parameter int NH = 8,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_cmd,
  input  logic [1:0]    req_policy,
  input  logic [AW-1:0] req_size,
  input  logic [AW-1:0] req_addr,
  output logic          busy,
  output logic          resp_valid,
  output logic [1:0]    resp_status,
  output logic [AW-1:0] resp_addr,
  output logic [AW-1:0] resp_size
);
  localparam int IW = $clog2(NH);
  localparam int CW = IW + 1;

  fsm_e          state;
  cmd_e          cmd_q;
  pol_e          pol_q;
  logic [AW-1:0] size_q, addr_q;
  logic [IW-1:0] idx, nf_ptr;
  logic [CW-1:0] cnt;

  logic [NH-1:0]         ent_valid;
  logic [NH-1:0][AW-1:0] ent_start, ent_size;

  logic          wa_en, wa_valid, wb_en;
  logic [IW-1:0] wa_idx, wb_idx;
  logic [AW-1:0] wa_start, wa_size;

  logic          fit_hit, sel_found, left_found, right_found, slot_found;
  logic [IW-1:0] sel_idx, left_idx, right_idx, slot_idx;
  logic [AW-1:0] sel_size;

  // Named events for the checker.
  logic ev_accept, ev_alloc_ok, ev_nofit, ev_split_zero, ev_merge_both, ev_overflow;

  stat_e         c_status;
  logic [AW-1:0] c_addr, c_size;
  logic          early_stop, last_entry;
  logic [IW-1:0] idx_next, rd_idx;

  assign busy      = (state != S_IDLE);
  assign ev_accept = req_valid && !busy;

  hole_table #(.NH(NH), .AW(AW)) u_table (
    .clk(clk), .rst_n(rst_n),
    .wa_en(wa_en), .wa_idx(wa_idx), .wa_valid(wa_valid), .wa_start(wa_start), .wa_size(wa_size),
    .wb_en(wb_en), .wb_idx(wb_idx),
    .ent_valid(ent_valid), .ent_start(ent_start), .ent_size(ent_size)
  );

  hole_scan #(.NH(NH), .AW(AW)) u_scan (
    .clk(clk), .rst_n(rst_n), .clear(ev_accept), .step(state == S_SCAN),
    .is_alloc(cmd_q == CMD_ALLOC), .policy(pol_q), .want_size(size_q), .want_addr(addr_q),
    .idx(idx), .ent_v(ent_valid[idx]), .ent_s(ent_start[idx]), .ent_z(ent_size[idx]),
    .fit_hit(fit_hit), .sel_found(sel_found), .sel_idx(sel_idx), .sel_size(sel_size),
    .left_found(left_found), .left_idx(left_idx), .right_found(right_found), .right_idx(right_idx),
    .slot_found(slot_found), .slot_idx(slot_idx)
  );

  function automatic logic [IW-1:0] wrap_inc(logic [IW-1:0] i);
    return (i == IW'(NH - 1)) ? '0 : i + 1'b1;
  endfunction

  assign idx_next   = wrap_inc(idx);
  assign last_entry = (cnt == CW'(NH - 1));
  assign early_stop = (cmd_q == CMD_ALLOC) && (pol_q == POL_FIRST || pol_q == POL_NEXT) && fit_hit;
  assign rd_idx     = addr_q[IW-1:0];

  // Commit-cycle decisions: table writes, response fields and events.
  always_comb begin
    wa_en = 1'b0; wa_idx = '0; wa_valid = 1'b0; wa_start = '0; wa_size = '0;
    wb_en = 1'b0; wb_idx = '0;
    c_status = ST_OK; c_addr = '0; c_size = '0;
    ev_alloc_ok = 1'b0; ev_nofit = 1'b0; ev_split_zero = 1'b0;
    ev_merge_both = 1'b0; ev_overflow = 1'b0;
    if (state == S_COMMIT) begin
      case (cmd_q)
        CMD_ALLOC: begin
          if (sel_found) begin
            ev_alloc_ok   = 1'b1;
            wa_en         = 1'b1;
            wa_idx        = sel_idx;
            wa_start      = ent_start[sel_idx] + size_q;
            wa_size       = sel_size - size_q;
            wa_valid      = (wa_size != '0);
            ev_split_zero = !wa_valid;
            c_addr        = ent_start[sel_idx];
            c_size        = wa_size;
          end else begin
            ev_nofit = 1'b1;
            c_status = ST_NOFIT;
          end
        end
        CMD_FREE: begin
          wa_valid = 1'b1;
          if (left_found && right_found) begin
            ev_merge_both = 1'b1;
            wa_en    = 1'b1;
            wa_idx   = left_idx;
            wa_start = ent_start[left_idx];
            wa_size  = ent_size[left_idx] + size_q + ent_size[right_idx];
            wb_en    = 1'b1;
            wb_idx   = right_idx;
          end else if (left_found) begin
            wa_en    = 1'b1;
            wa_idx   = left_idx;
            wa_start = ent_start[left_idx];
            wa_size  = ent_size[left_idx] + size_q;
          end else if (right_found) begin
            wa_en    = 1'b1;
            wa_idx   = right_idx;
            wa_start = addr_q;
            wa_size  = ent_size[right_idx] + size_q;
          end else if (slot_found) begin
            wa_en    = 1'b1;
            wa_idx   = slot_idx;
            wa_start = addr_q;
            wa_size  = size_q;
          end else begin
            ev_overflow = 1'b1;
            c_status    = ST_OVFL;
          end
          if (wa_en) begin
            c_addr = wa_start;
            c_size = wa_size;
          end
        end
        default: begin
          if (ent_valid[rd_idx]) begin
            c_addr = ent_start[rd_idx];
            c_size = ent_size[rd_idx];
          end else begin
            c_status = ST_EMPTY;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      cmd_q       <= CMD_ALLOC;
      pol_q       <= POL_FIRST;
      size_q      <= '0;
      addr_q      <= '0;
      idx         <= '0;
      cnt         <= '0;
      nf_ptr      <= '0;
      resp_valid  <= 1'b0;
      resp_status <= 2'd0;
      resp_addr   <= '0;
      resp_size   <= '0;
    end else begin
      resp_valid <= 1'b0;
      case (state)
        S_IDLE: begin
          if (ev_accept) begin
            cmd_q  <= cmd_e'(req_cmd);
            pol_q  <= pol_e'(req_policy);
            size_q <= req_size;
            addr_q <= req_addr;
            cnt    <= '0;
            idx    <= (req_cmd == CMD_ALLOC && req_policy == POL_NEXT) ? nf_ptr : '0;
            state  <= (req_cmd == CMD_ALLOC || req_cmd == CMD_FREE) ? S_SCAN : S_COMMIT;
          end
        end
        S_SCAN: begin
          cnt <= cnt + 1'b1;
          idx <= idx_next;
          if (early_stop || last_entry) state <= S_COMMIT;
        end
        default: begin
          resp_valid  <= 1'b1;
          resp_status <= c_status;
          resp_addr   <= c_addr;
          resp_size   <= c_size;
          if (ev_alloc_ok) nf_ptr <= sel_idx;
          state <= S_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/hole_alloc_chk.sv
module hole_alloc_chk #(
  parameter int NH = 8,
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          resp_valid,
  input logic [1:0]    resp_status,
  input logic [AW-1:0] resp_addr,
  input logic [AW-1:0] resp_size,
  input logic          ev_accept,
  input logic          ev_alloc_ok,
  input logic          ev_nofit,
  input logic          ev_split_zero,
  input logic          ev_merge_both,
  input logic          ev_overflow
);
  logic [15:0] busy_run;

  always_ff @(posedge clk) begin
    if (!rst_n)    busy_run <= '0;
    else if (busy) busy_run <= busy_run + 16'd1;
    else           busy_run <= '0;
  end

  assert_busy_after_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> busy);
  assert_resp_when_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> !busy);
  assert_resp_follows_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $past(busy));
  assert_scan_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (busy_run <= 16'(NH)));
  assert_alloc_ok_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_alloc_ok |=> (resp_valid && resp_status == 2'd0));
  assert_no_fit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_nofit |=> (resp_valid && resp_status == 2'd1 && resp_addr == '0));
  assert_split_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_split_zero |=> (resp_valid && resp_size == '0));
  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_overflow |=> (resp_valid && resp_status == 2'd2));
  assert_merge_both_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_merge_both |=> (resp_valid && resp_status == 2'd0));
endmodule

bind hole_alloc hole_alloc_chk #(.NH(NH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .resp_valid(resp_valid),
  .resp_status(resp_status), .resp_addr(resp_addr), .resp_size(resp_size),
  .ev_accept(ev_accept), .ev_alloc_ok(ev_alloc_ok), .ev_nofit(ev_nofit),
  .ev_split_zero(ev_split_zero), .ev_merge_both(ev_merge_both), .ev_overflow(ev_overflow)
);

// File: tb/hole_alloc_tb.sv
`timescale 1ns/1ps
module hole_alloc_tb;
  localparam int NH = 8;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [1:0]    req_cmd = 2'd0;
  logic [1:0]    req_policy = 2'd0;
  logic [AW-1:0] req_size = '0;
  logic [AW-1:0] req_addr = '0;
  logic          busy, resp_valid;
  logic [1:0]    resp_status;
  logic [AW-1:0] resp_addr, resp_size;

  always #2.5 clk = ~clk;

  hole_alloc #(.NH(NH), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_policy(req_policy), .req_size(req_size), .req_addr(req_addr),
    .busy(busy), .resp_valid(resp_valid), .resp_status(resp_status),
    .resp_addr(resp_addr), .resp_size(resp_size)
  );

  // Vectors: policy, request, expected address (-1 means no fit).
  localparam int VPOL[16]  = '{0,0,0,0, 1,1,1,1, 2,2,2,2, 3,3,3,3};
  localparam int VSZ[16]   = '{212,417,112,426, 212,417,112,426, 212,417,112,426, 212,417,112,426};
  localparam int VADDR[16] = '{1000,4000,1212,-1, 1000,4000,4417,-1,
                               3000,1000,2000,4000, 4000,1000,4212,-1};
  localparam int FIN[20]   = '{100,176,200,300,183, 100,288,200,300,71,
                               100,83,88,88,174, 100,83,200,300,276};

  int  n_run = 0;
  int  n_fail = 0;
  bit  hung = 0;
  bit  done = 0;
  int  st, ra, rs, cyc;

  function automatic string ptag(int p);
    case (p)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_req(input int cmd, input int pol, input int size, input int addr,
                        output int o_st, output int o_ra, output int o_rs, output int o_cyc);
    @(negedge clk);
    req_valid  = 1'b1;
    req_cmd    = cmd[1:0];
    req_policy = pol[1:0];
    req_size   = size[AW-1:0];
    req_addr   = addr[AW-1:0];
    @(posedge clk);
    #1 req_valid = 1'b0;
    o_cyc = 0;
    while (1) begin
      @(negedge clk);
      if (resp_valid) break;
      o_cyc++;
      if (o_cyc > 1000) begin
        hung = 1;
        break;
      end
    end
    o_st = resp_status;
    o_ra = resp_addr;
    o_rs = resp_size;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic load5();
    int s, a, z, c;
    do_req(1, 0, 100, 0, s, a, z, c);
    do_req(1, 0, 500, 1000, s, a, z, c);
    do_req(1, 0, 200, 2000, s, a, z, c);
    do_req(1, 0, 300, 3000, s, a, z, c);
    do_req(1, 0, 600, 4000, s, a, z, c);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1: reset state
    chk("R1 busy after reset", busy, 0);
    chk("R1 resp_valid after reset", resp_valid, 0);
    do_req(2, 0, 0, 0, st, ra, rs, cyc);
    chk("R1 entry0 empty", st, 3);
    chk("R11 read latency", cyc, 1);
    do_req(2, 0, 0, 7, st, ra, rs, cyc);
    chk("R1 entry7 empty", st, 3);
    chk("R1 entry7 size", rs, 0);

    // Vector walk over the four policies
    for (int r = 0; r < 16; r++) begin
      if (r % 4 == 0) begin
        do_reset();
        load5();
      end
      do_req(0, VPOL[r], VSZ[r], 0, st, ra, rs, cyc);
      if (VADDR[r] < 0) begin
        chk({ptag(VPOL[r]), " R6 nofit status"}, st, 1);
        chk("R6 nofit addr", ra, 0);
      end else begin
        chk({ptag(VPOL[r]), " status"}, st, 0);
        chk({ptag(VPOL[r]), " addr"}, ra, VADDR[r]);
      end
      if (r == 0) chk("R11 first fit hit at entry 1", cyc, 3);
      if (r % 4 == 3) begin
        for (int e = 0; e < 5; e++) begin
          do_req(2, 0, 0, e, st, ra, rs, cyc);
          chk({ptag(VPOL[r]), " R12 final hole size"}, rs, FIN[(r / 4) * 5 + e]);
        end
      end
    end

    // R11 full scan latency, R4 best fit
    do_reset();
    load5();
    do_req(0, 2, 50, 0, st, ra, rs, cyc);
    chk("R11 best fit latency", cyc, NH + 1);
    chk("R4 best picks 100 hole", ra, 0);
    chk("R7 leftover size", rs, 50);

    // R7 / R8: exact consume
    do_reset();
    do_req(1, 0, 100, 0, st, ra, rs, cyc);
    chk("R8 free status", st, 0);
    chk("R8 free size", rs, 100);
    chk("R11 free latency", cyc, NH + 1);
    do_req(0, 0, 100, 0, st, ra, rs, cyc);
    chk("R7 full consume addr", ra, 0);
    chk("R7 full consume leftover", rs, 0);
    do_req(2, 0, 0, 0, st, ra, rs, cyc);
    chk("R7 consumed entry empty", st, 3);

    // R9 merges
    do_reset();
    do_req(1, 0, 100, 0, st, ra, rs, cyc);
    do_req(1, 0, 100, 200, st, ra, rs, cyc);
    do_req(1, 0, 100, 100, st, ra, rs, cyc);
    chk("R9 both merge status", st, 0);
    chk("R9 both merge addr", ra, 0);
    chk("R9 both merge size", rs, 300);
    do_req(2, 0, 0, 1, st, ra, rs, cyc);
    chk("R9 upper entry emptied", st, 3);
    do_req(2, 0, 0, 0, st, ra, rs, cyc);
    chk("R9 lower entry size", rs, 300);
    do_req(1, 0, 50, 300, st, ra, rs, cyc);
    chk("R9 left merge size", rs, 350);
    do_req(1, 0, 20, 500, st, ra, rs, cyc);
    chk("R8 new hole addr", ra, 500);
    do_req(2, 0, 0, 1, st, ra, rs, cyc);
    chk("R8 lowest empty entry used", ra, 500);
    do_req(1, 0, 20, 480, st, ra, rs, cyc);
    chk("R9 right merge addr", ra, 480);
    chk("R9 right merge size", rs, 40);
    do_req(2, 0, 0, 1, st, ra, rs, cyc);
    chk("R9 right entry start", ra, 480);

    // R10 overflow
    do_reset();
    for (int i = 0; i < NH; i++) do_req(1, 0, 10, i * 100, st, ra, rs, cyc);
    do_req(1, 0, 10, 5000, st, ra, rs, cyc);
    chk("R10 overflow status", st, 2);
    for (int i = 0; i < NH; i++) begin
      do_req(2, 0, 0, i, st, ra, rs, cyc);
      chk("R10 table unchanged start", ra, i * 100);
      chk("R10 table unchanged size", rs, 10);
    end
    do_req(1, 0, 5, 10, st, ra, rs, cyc);
    chk("R9 merge when full status", st, 0);
    chk("R9 merge when full size", rs, 15);

    // R4 / R5 ties
    do_reset();
    do_req(1, 0, 100, 0, st, ra, rs, cyc);
    do_req(1, 0, 100, 200, st, ra, rs, cyc);
    do_req(1, 0, 300, 400, st, ra, rs, cyc);
    do_req(1, 0, 300, 800, st, ra, rs, cyc);
    do_req(0, 2, 50, 0, st, ra, rs, cyc);
    chk("R4 tie lowest index", ra, 0);
    do_req(0, 3, 50, 0, st, ra, rs, cyc);
    chk("R5 tie lowest index", ra, 400);

    // R3 next fit resume and wrap
    do_reset();
    do_req(1, 0, 100, 0, st, ra, rs, cyc);
    do_req(1, 0, 100, 200, st, ra, rs, cyc);
    do_req(0, 1, 50, 0, st, ra, rs, cyc);
    chk("R3 first next-fit", ra, 0);
    do_req(0, 1, 60, 0, st, ra, rs, cyc);
    chk("R3 skip small hole", ra, 200);
    do_req(0, 1, 40, 0, st, ra, rs, cyc);
    chk("R3 resume at last index", ra, 260);
    do_req(0, 1, 30, 0, st, ra, rs, cyc);
    chk("R3 wrap addr", ra, 50);
    chk("R11 next fit wrap latency", cyc, NH + 1);

    if (hung) chk("watchdog response", 0, 1);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule